// File: doc/BRIEF.md
# Dual Page Buffer Write Engine

This block stages data for a block-erasable array in two 256-byte page buffers and later copies a run of bytes from the active buffer into the array. A host issues commands as single bus writes on a shared address/data port. A command cycle is followed by a two-cycle length field, which is sent as the number of units minus one. A fill command then takes that many address/data cycles into the active buffer. A commit command instead takes one destination-address cycle, and the engine then streams bytes to the array. A separate command switches which of the two buffers is active, so software can fill one buffer while the content of the other is kept for a later commit.

The host port runs either byte-wide or word-wide, selected per cycle by a byte-mode flag. In byte-wide mode, address bit 0 of the first length cycle selects whether the low or the high length byte comes first, and the second cycle carries the other byte whatever its own bit 0. In word-wide mode only data bits 7:0 carry the length bytes, low byte first. The high length byte must be zero. A transfer always stays within one 256-byte segment: the buffer offset and the low eight address bits are the same, and they wrap within the segment. A bad length aborts the command and raises a sticky write-error flag.

Control states: S_IDLE (command decode), S_CNT_A (first length byte), S_CNT_B (second length byte, length check), S_FILL (buffer loading), S_DEST (destination address), S_XFER (array transfer). Transitions: S_IDLE to S_CNT_A on a fill or commit command. S_CNT_A to S_CNT_B on any write. S_CNT_B to S_IDLE on a bad length, to S_FILL for a good fill, and to S_DEST for a good commit. S_FILL to S_IDLE after the last unit. S_DEST to S_XFER on the address write. S_XFER to S_IDLE when the array acknowledges the last byte.

Top module: `pgbuf_engine`

## Requirements
- R1: After reset, busy, wr_err and arr_req are 0, buffer 0 is active, and both buffers hold all-zero bytes.
- R2: Command codes sit in data bits 7:0 of a write in S_IDLE: E0h fill, 0Ch commit, 72h swap, 50h clear error. A byte-wide fill of N+1 bytes stores data bits 7:0 of each data cycle at buffer offset address[7:0] of the active buffer. Data bits 15:8 are ignored.
- R3: In byte-wide mode, address bit 0 of the first length cycle selects the order: 0 means low length byte first, 1 means high length byte first. The second length cycle supplies the other byte.
- R4: In word-wide mode the length bytes come from data bits 7:0 only, low byte then high byte. Each data word is stored with bits 7:0 at even offset {address[7:1],0} and bits 15:8 at the next odd offset.
- R5: A length byte of 00h means exactly one byte, or one word. In general the unit count is the length byte plus one.
- R6: A non-zero high length byte aborts the command. wr_err is set, no array write occurs and no buffer byte changes.
- R7: In word-wide mode a low length byte above 7Fh aborts the command in the same way as R6.
- R8: A commit writes bytes from the active buffer to the array in increasing order. It starts at offset dest[7:0] in byte-wide mode, or at dest[7:1],0 in word-wide mode. Each array address is {dest[20:8], offset}, the offset wraps modulo 256, and a word-wide commit writes twice the unit count in bytes.
- R9: busy is 1 from the cycle after the destination write until the last byte is acknowledged. Host writes during that time are ignored.
- R10: The swap command toggles the active buffer for later fills and commits.
- R11: A commit leaves buffer content unchanged, so a repeated commit writes identical bytes.
- R12: The clear command returns wr_err to 0. Unknown command codes in S_IDLE have no effect.
- R13: arr_req with its address holds steady until arr_done is seen, and each acknowledged byte moves the address by one within the same segment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_we | input | 1 | Host write strobe, one write per cycle |
| hw_addr | input | ADDR_W | Host byte address |
| hw_data | input | 16 | Host write data |
| hw_byte_mode | input | 1 | 1 = byte-wide cycle, 0 = word-wide cycle |
| arr_req | output | 1 | Array byte write request |
| arr_addr | output | ADDR_W | Array byte address |
| arr_data | output | 8 | Array byte data |
| arr_done | input | 1 | Array acknowledge for the current byte |
| busy | output | 1 | Transfer in progress |
| wr_err | output | 1 | Sticky data-write error flag |

## Verification
A corrupted unit counter shows up as a transfer log of the wrong length as soon as busy drops after the next commit. A wrong offset or segment register gives a mismatching array address on the first byte written. A swapped length-byte order or a misread upper byte appears one cycle after the second length write, either as a false wr_err or as a wrong transfer length. A buffer selected wrongly, or a buffer damaged by a commit, is exposed by the first commit that follows, because the bench compares every byte against its own model of both buffers.

// File: rtl/pgbuf_pkg.sv
package pgbuf_pkg;

    localparam int DATA_W = 16;
    localparam int CNT_W  = 8;
    localparam int NBUF   = 2;

    localparam logic [7:0] CMD_FILL   = 8'hE0;
    localparam logic [7:0] CMD_COMMIT = 8'h0C;
    localparam logic [7:0] CMD_SWAP   = 8'h72;
    localparam logic [7:0] CMD_CLR    = 8'h50;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CNT_A,
        S_CNT_B,
        S_FILL,
        S_DEST,
        S_XFER
    } pg_state_t;

endpackage

// File: rtl/pgbuf_store.sv
module pgbuf_store
    import pgbuf_pkg::*;
#(
    parameter int SEG_BYTES = 256,
    localparam int OFF_W = $clog2(SEG_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              wide,
    input  logic              wsel,
    input  logic [OFF_W-1:0]  woff,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rsel,
    input  logic [OFF_W-1:0]  roff,
    output logic [7:0]        rdata
);

    logic [7:0] bank_rd [NBUF];

    for (genvar b = 0; b < NBUF; b++) begin : g_bank
        logic [7:0] mem [SEG_BYTES];
        logic       hit;

        assign hit = we && (wsel == b[0]);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < SEG_BYTES; i++) mem[i] <= '0;
            end else if (hit) begin
                if (wide) begin
                    mem[{woff[OFF_W-1:1], 1'b0}] <= wdata[7:0];
                    mem[{woff[OFF_W-1:1], 1'b1}] <= wdata[15:8];
                end else begin
                    mem[woff] <= wdata[7:0];
                end
            end
        end

        assign bank_rd[b] = mem[roff];
    end

    assign rdata = bank_rd[rsel];

    // R4: a word write must land on an even offset
    AST_WIDE_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wide) |-> (woff[0] == 1'b0)); // R4

endmodule

// File: rtl/pgbuf_ctrl.sv
module pgbuf_ctrl
    import pgbuf_pkg::*;
#(
    parameter int ADDR_W    = 21,
    parameter int SEG_BYTES = 256,
    localparam int OFF_W    = $clog2(SEG_BYTES),
    localparam int SEG_W    = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_we,
    input  logic [ADDR_W-1:0] hw_addr,
    input  logic [DATA_W-1:0] hw_data,
    input  logic              hw_byte_mode,
    input  logic              arr_done,
    output logic              arr_req,
    output logic [ADDR_W-1:0] arr_addr,
    output logic              busy,
    output logic              wr_err,
    output logic              buf_we,
    output logic              buf_wide,
    output logic              buf_wsel,
    output logic [OFF_W-1:0]  buf_woff,
    output logic [DATA_W-1:0] buf_wdata,
    output logic              buf_rsel,
    output logic [OFF_W-1:0]  buf_roff
);

    localparam logic [CNT_W-1:0] WORD_MAX = CNT_W'(SEG_BYTES / 2 - 1);

    pg_state_t        st, st_nx;
    logic             mode16;
    logic             is_commit;
    logic             first_hi;
    logic             active;
    logic [CNT_W-1:0] cnt_lo, cnt_hi;
    logic [OFF_W-1:0] rem;
    logic [OFF_W-1:0] off;
    logic [SEG_W-1:0] seg;

    logic [7:0]       cmd;
    logic [CNT_W-1:0] lo_n, hi_n;
    logic             len_bad;

    assign cmd     = hw_data[7:0];
    assign lo_n    = first_hi ? hw_data[7:0] : cnt_lo;
    assign hi_n    = first_hi ? cnt_hi : hw_data[7:0];
    assign len_bad = (hi_n != '0) || (mode16 && (lo_n > WORD_MAX));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    // next state
    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE: begin
                if (hw_we && (cmd == CMD_FILL || cmd == CMD_COMMIT))
                    st_nx = S_CNT_A;
            end
            S_CNT_A: begin
                if (hw_we) st_nx = S_CNT_B;
            end
            S_CNT_B: begin
                if (hw_we) begin
                    if (len_bad)        st_nx = S_IDLE;
                    else if (is_commit) st_nx = S_DEST;
                    else                st_nx = S_FILL;
                end
            end
            S_FILL: begin
                if (hw_we && rem == '0) st_nx = S_IDLE;
            end
            S_DEST: begin
                if (hw_we) st_nx = S_XFER;
            end
            S_XFER: begin
                if (arr_done && rem == '0) st_nx = S_IDLE;
            end
            default: st_nx = S_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode16    <= 1'b0;
            is_commit <= 1'b0;
            first_hi  <= 1'b0;
            active    <= 1'b0;
            cnt_lo    <= '0;
            cnt_hi    <= '0;
            rem       <= '0;
            off       <= '0;
            seg       <= '0;
            wr_err    <= 1'b0;
        end else begin
            unique case (st)
                S_IDLE: begin
                    if (hw_we) begin
                        if (cmd == CMD_FILL || cmd == CMD_COMMIT) begin
                            mode16    <= !hw_byte_mode;
                            is_commit <= (cmd == CMD_COMMIT);
                        end else if (cmd == CMD_SWAP) begin
                            active <= ~active;
                        end else if (cmd == CMD_CLR) begin
                            wr_err <= 1'b0;
                        end
                    end
                end
                S_CNT_A: begin
                    if (hw_we) begin
                        first_hi <= !mode16 && hw_addr[0];
                        if (!mode16 && hw_addr[0]) cnt_hi <= hw_data[7:0];
                        else                       cnt_lo <= hw_data[7:0];
                    end
                end
                S_CNT_B: begin
                    if (hw_we) begin
                        cnt_lo <= lo_n;
                        cnt_hi <= hi_n;
                        if (len_bad) wr_err <= 1'b1;
                        else if (mode16 && is_commit) rem <= OFF_W'({lo_n, 1'b1});
                        else rem <= OFF_W'(lo_n);
                    end
                end
                S_FILL: begin
                    if (hw_we) rem <= rem - 1'b1;
                end
                S_DEST: begin
                    if (hw_we) begin
                        seg <= hw_addr[ADDR_W-1:OFF_W];
                        off <= mode16 ? {hw_addr[OFF_W-1:1], 1'b0} : hw_addr[OFF_W-1:0];
                    end
                end
                S_XFER: begin
                    if (arr_done) begin
                        off <= off + 1'b1;
                        rem <= rem - 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        arr_req   = (st == S_XFER);
        busy      = (st == S_XFER);
        arr_addr  = {seg, off};
        buf_we    = (st == S_FILL) && hw_we;
        buf_wide  = mode16;
        buf_wsel  = active;
        buf_woff  = mode16 ? {hw_addr[OFF_W-1:1], 1'b0} : hw_addr[OFF_W-1:0];
        buf_wdata = hw_data;
        buf_rsel  = active;
        buf_roff  = off;
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_req && !arr_done) |=> (arr_req && $stable(arr_addr))); // R13

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_req && arr_done) |=> (!arr_req ||
            (arr_addr[ADDR_W-1:OFF_W] == $past(arr_addr[ADDR_W-1:OFF_W]) &&
             arr_addr[OFF_W-1:0] == $past(arr_addr[OFF_W-1:0]) + 1'b1))); // R8

    AST_ERR_NO_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_err) |-> !busy); // R6

    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !arr_done) |=> busy); // R9

    AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE && hw_we && cmd == CMD_CLR) |=> !wr_err); // R12

    AST_NO_FILL_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !buf_we); // R11

endmodule

// File: rtl/pgbuf_engine.sv
module pgbuf_engine
    import pgbuf_pkg::*;
#(
    parameter int ADDR_W    = 21,
    parameter int SEG_BYTES = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_we,
    input  logic [ADDR_W-1:0] hw_addr,
    input  logic [15:0]       hw_data,
    input  logic              hw_byte_mode,
    output logic              arr_req,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [7:0]        arr_data,
    input  logic              arr_done,
    output logic              busy,
    output logic              wr_err
);

    localparam int OFF_W = $clog2(SEG_BYTES);

    logic              buf_we, buf_wide, buf_wsel, buf_rsel;
    logic [OFF_W-1:0]  buf_woff, buf_roff;
    logic [DATA_W-1:0] buf_wdata;

    pgbuf_ctrl #(
        .ADDR_W    (ADDR_W),
        .SEG_BYTES (SEG_BYTES)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .hw_we        (hw_we),
        .hw_addr      (hw_addr),
        .hw_data      (hw_data),
        .hw_byte_mode (hw_byte_mode),
        .arr_done     (arr_done),
        .arr_req      (arr_req),
        .arr_addr     (arr_addr),
        .busy         (busy),
        .wr_err       (wr_err),
        .buf_we       (buf_we),
        .buf_wide     (buf_wide),
        .buf_wsel     (buf_wsel),
        .buf_woff     (buf_woff),
        .buf_wdata    (buf_wdata),
        .buf_rsel     (buf_rsel),
        .buf_roff     (buf_roff)
    );

    pgbuf_store #(
        .SEG_BYTES (SEG_BYTES)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (buf_we),
        .wide  (buf_wide),
        .wsel  (buf_wsel),
        .woff  (buf_woff),
        .wdata (buf_wdata),
        .rsel  (buf_rsel),
        .roff  (buf_roff),
        .rdata (arr_data)
    );

endmodule

// File: tb/tb_pgbuf_engine.sv
module tb_pgbuf_engine;

    localparam int AW = 21;
    localparam logic [7:0] C_FILL = 8'hE0, C_COMMIT = 8'h0C, C_SWAP = 8'h72, C_CLR = 8'h50;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hw_we = 1'b0;
    logic [AW-1:0] hw_addr = '0;
    logic [15:0]   hw_data = '0;
    logic          hw_byte_mode = 1'b1;
    logic          arr_req, arr_done, busy, wr_err;
    logic [AW-1:0] arr_addr;
    logic [7:0]    arr_data;

    int tests = 0;
    int fails = 0;
    int seed_dummy;

    logic [7:0]    bm [2][256];
    int            act_m = 0;
    logic [AW-1:0] log_a [$];
    logic [7:0]    log_d [$];

    always #10 clk = ~clk;

    pgbuf_engine #(.ADDR_W(AW), .SEG_BYTES(256)) dut (
        .clk(clk), .rst_n(rst_n), .hw_we(hw_we), .hw_addr(hw_addr),
        .hw_data(hw_data), .hw_byte_mode(hw_byte_mode), .arr_req(arr_req),
        .arr_addr(arr_addr), .arr_data(arr_data), .arr_done(arr_done),
        .busy(busy), .wr_err(wr_err)
    );

    // array responder: one cycle to acknowledge each byte
    always @(posedge clk) begin
        if (!rst_n) arr_done <= 1'b0;
        else if (arr_done) arr_done <= 1'b0;
        else if (arr_req) begin
            log_a.push_back(arr_addr);
            log_d.push_back(arr_data);
            arr_done <= 1'b1;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic hw(input logic [AW-1:0] a, input logic [15:0] d, input logic bmode);
        @(negedge clk);
        hw_we = 1'b1; hw_addr = a; hw_data = d; hw_byte_mode = bmode;
    endtask

    task automatic quiet();
        @(negedge clk);
        hw_we = 1'b0;
    endtask

    task automatic send_cnt(input bit m16, input bit a0f, input logic [7:0] lo, input logic [7:0] hi);
        logic [7:0] junk;
        junk = 8'($urandom);
        if (m16) begin
            hw(AW'(0), {junk, lo}, 1'b0);
            hw(AW'(1), {~junk, hi}, 1'b0);
        end else begin
            hw(AW'(a0f), {junk, a0f ? hi : lo}, 1'b1);
            hw(AW'(a0f), {junk, a0f ? lo : hi}, 1'b1);
        end
    endtask

    task automatic do_fill(input bit m16, input bit a0f, input int cnt, input int start);
        hw(AW'($urandom), {8'h00, C_FILL}, !m16);
        send_cnt(m16, a0f, 8'(cnt), 8'h00);
        for (int i = 0; i <= cnt; i++) begin
            logic [15:0] d;
            logic [7:0]  o;
            logic [12:0] sg;
            d  = 16'($urandom);
            sg = 13'($urandom);
            if (m16) begin
                o = 8'((start & 8'hFE) + 2 * i);
                hw({sg, o | 8'(i & 1)}, d, 1'b0);  // A0 ignored in word mode
                bm[act_m][{o[7:1], 1'b0}] = d[7:0];
                bm[act_m][{o[7:1], 1'b1}] = d[15:8];
            end else begin
                o = 8'(start + i);
                hw({sg, o}, d, 1'b1);
                bm[act_m][o] = d[7:0];
            end
        end
        quiet();
    endtask

    task automatic do_commit(input bit m16, input bit a0f, input int cnt,
                             input logic [AW-1:0] dest, input bit junk, input string tag);
        int nb, bad_i, lim;
        logic [7:0] o0;
        log_a.delete(); log_d.delete();
        hw(AW'(0), {8'h00, C_COMMIT}, !m16);
        send_cnt(m16, a0f, 8'(cnt), 8'h00);
        hw(dest, 16'($urandom), !m16);
        if (junk) begin
            hw(AW'(0), {8'h00, C_SWAP}, 1'b1);
            chk(busy === 1'b1, "R9 busy after destination", busy, 1);
            hw(AW'(0), {8'h00, C_FILL}, 1'b1);
            hw(AW'(0), 16'h0000, 1'b1);
            hw(AW'(0), 16'h0000, 1'b1);
            hw(AW'(3), 16'h00AA, 1'b1);
            quiet();
        end else begin
            quiet();
            chk(busy === 1'b1, "R9 busy after destination", busy, 1);
        end
        lim = 0;
        while (busy && lim < 2000) begin @(negedge clk); lim++; end
        nb = m16 ? 2 * (cnt + 1) : cnt + 1;
        o0 = m16 ? (dest[7:0] & 8'hFE) : dest[7:0];
        bad_i = -1;
        if (log_a.size() == nb) begin
            for (int i = 0; i < nb; i++) begin
                logic [7:0] o;
                o = 8'(o0 + i);
                if (bad_i < 0 && (log_a[i] !== {dest[AW-1:8], o} || log_d[i] !== bm[act_m][o]))
                    bad_i = i;
            end
        end
        chk(log_a.size() == nb, {tag, " length"}, log_a.size(), nb);
        if (bad_i >= 0)
            chk(1'b0, {tag, " data/addr"}, int'({log_a[bad_i], log_d[bad_i]}),
                int'({dest[AW-1:8], 8'(o0 + bad_i), bm[act_m][8'(o0 + bad_i)]}));
        else
            chk(1'b1, tag, 0, 0);
    endtask

    task automatic bad_len(input bit m16, input bit commit, input logic [7:0] lo,
                           input logic [7:0] hi, input string tag);
        log_a.delete(); log_d.delete();
        hw(AW'(0), {8'h00, commit ? C_COMMIT : C_FILL}, !m16);
        send_cnt(m16, 1'b0, lo, hi);
        quiet();
        chk(wr_err === 1'b1, {tag, " error set"}, wr_err, 1);
        repeat (6) @(negedge clk);
        chk(log_a.size() == 0 && busy === 1'b0, {tag, " no array write"}, log_a.size(), 0);
        hw(AW'(0), {8'h00, C_CLR}, 1'b1);
        quiet();
        chk(wr_err === 1'b0, "R12 clear error", wr_err, 0);
    endtask

    task automatic do_swap();
        hw(AW'(0), {8'h00, C_SWAP}, 1'b1);
        quiet();
        act_m ^= 1;
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        seed_dummy = $urandom(32'd7351);
        for (int b = 0; b < 2; b++)
            for (int i = 0; i < 256; i++) bm[b][i] = 8'h00;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy === 1'b0, "R1 busy at reset", busy, 0);
        chk(wr_err === 1'b0, "R1 error at reset", wr_err, 0);
        chk(arr_req === 1'b0, "R1 request at reset", arr_req, 0);
        do_commit(1'b0, 1'b0, 15, 21'h012340, 1'b0, "R1 zero buffer");

        // byte-wide fill and commit, both count orders
        do_fill(1'b0, 1'b0, 31, 8'h10);
        do_commit(1'b0, 1'b0, 31, 21'h1A5510, 1'b0, "R2 byte fill/commit");
        do_fill(1'b0, 1'b1, 4, 8'h80);
        do_commit(1'b0, 1'b1, 4, 21'h000080, 1'b0, "R3 high byte first");

        // single-unit lengths
        do_fill(1'b0, 1'b0, 0, 8'h42);
        do_commit(1'b0, 1'b1, 0, 21'h0ABC42, 1'b0, "R5 one byte");
        do_fill(1'b1, 1'b0, 0, 8'h60);
        do_commit(1'b1, 1'b0, 0, 21'h033361, 1'b0, "R5 one word");

        // word-wide with junk upper count bytes
        do_fill(1'b1, 1'b0, 19, 8'hC4);
        do_commit(1'b1, 1'b0, 19, 21'h1FFFC5, 1'b0, "R4 word fill/commit");

        // wrap inside segment
        do_fill(1'b0, 1'b0, 15, 8'hF8);
        do_commit(1'b0, 1'b0, 15, 21'h0456F8, 1'b0, "R8 offset wrap");

        // buffer unchanged by commit
        do_commit(1'b0, 1'b0, 31, 21'h1A5510, 1'b0, "R11 repeat commit");

        // swap
        do_swap();
        do_fill(1'b0, 1'b0, 31, 8'h10);
        do_commit(1'b0, 1'b0, 31, 21'h002210, 1'b0, "R10 second buffer");
        do_swap();
        do_commit(1'b0, 1'b0, 31, 21'h002210, 1'b0, "R10 first buffer kept");

        // writes during busy ignored
        do_commit(1'b0, 1'b0, 20, 21'h007700, 1'b1, "R9 ignore while busy");
        do_commit(1'b0, 1'b0, 20, 21'h007700, 1'b0, "R9 state after busy");

        // bad lengths
        bad_len(1'b0, 1'b1, 8'h03, 8'h01, "R6 commit high count");
        bad_len(1'b0, 1'b0, 8'h03, 8'h80, "R6 fill high count");
        do_commit(1'b0, 1'b0, 255, 21'h100000, 1'b0, "R6 buffer untouched");
        bad_len(1'b1, 1'b1, 8'h80, 8'h00, "R7 word count too large");

        // unknown command
        hw(AW'(0), 16'h0033, 1'b1);
        quiet();
        @(negedge clk);
        chk(busy === 1'b0 && wr_err === 1'b0, "R12 unknown command", {busy, wr_err}, 0);
        do_commit(1'b0, 1'b0, 7, 21'h000300, 1'b0, "R12 normal after unknown");

        // constrained random
        for (int it = 0; it < 24; it++) begin
            bit m16, a0f;
            int cf, cc, st;
            logic [AW-1:0] ds;
            m16 = 1'($urandom);
            a0f = 1'($urandom);
            cf  = m16 ? int'($urandom % 128) : int'($urandom % 256);
            st  = int'($urandom % 256);
            do_fill(m16, a0f, cf, st);
            if ($urandom % 4 == 0) do_swap();
            m16 = 1'($urandom);
            cc  = m16 ? int'($urandom % 128) : int'($urandom % 256);
            ds  = AW'($urandom);
            do_commit(m16, 1'($urandom), cc, ds, 1'b0, "R8 random commit");
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule